// File: doc/BRIEF.md
# Scanline Vertical Timing Generator

This block produces the frame-level timing of a raster display controller. It counts scan lines, one per advance of the line clock, and from that count it derives the vertical active-display window, the vertical blanking interval and the vertical sync pulse. It also raises a one-cycle pulse when a new frame begins and another when the count reaches a programmed split line, so that address logic can restart its fetch there for a split screen.

The block runs on the system clock. The horizontal timer raises `line_end` for one cycle at the end of every scan line. When `div2` is set, only every second `line_end` advances the count, which halves the line clock and lets a 10-bit count cover up to 2048 physical lines. All programmed values arrive as plain inputs. Each 10-bit value is assembled before it reaches the block. Blanking and sync each run through a two-state window machine with the states IDLE and ACTIVE. The Enter transition, IDLE to ACTIVE, fires when the next count equals the full 10-bit start value. The Leave transition, ACTIVE to IDLE, fires when the low bits of the next count equal the short end field: 8 bits for blanking and 4 bits for sync.

Top module: `vtiming_gen`

## Requirements
- R1: After reset, `line_cnt` is 0, `vblank`, `vsync`, `frame_start` and `split_hit` are 0, and `vde` is 1 whenever `vdisp_end` is non-zero.
- R2: Each advance raises `line_cnt` by one. On the advance that follows the line where `line_cnt` equals `vtotal`, the count returns to 0 and `frame_start` is 1 for exactly that one cycle. If no `line_end` arrives, the count does not change.
- R3: `vde` is 1 exactly while `line_cnt` is below `vdisp_end`.
- R4: `vblank` rises in the cycle where `line_cnt` first equals `vblank_start`, compared on all 10 bits. A start value above `vtotal` never blanks.
- R5: `vblank` falls on the first later line where `line_cnt[7:0]` equals `vblank_end`, and that line is not blanked. If no such line comes before the wrap, blanking continues into the next frame until it does.
- R6: The sync window opens on the line where `line_cnt` equals `vsync_start`. It closes on the first later line where `line_cnt[3:0]` equals `vsync_end`, and that closing line is outside the window. The window carries across a wrap in the same way as in R5.
- R7: With `div2` = 1, the count advances on every second `line_end`. After reset, the first `line_end` leaves `line_cnt` at 0 and the second one raises it to 1.
- R8: With `sync_en` = 0, `vsync` is held at 0 while the sync window keeps running. Setting `sync_en` back to 1 inside an open window drives `vsync` high at once.
- R9: `split_hit` is 1 for one cycle when `line_cnt` becomes equal to `split_line`. A split value of 3FFh gives no pulse when `vtotal` is smaller than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_end | input | 1 | One-cycle pulse at the end of each scan line |
| div2 | input | 1 | Advance the count on every second line only |
| sync_en | input | 1 | 0 holds `vsync` inactive |
| vtotal | input | 10 | Count of the last line in a frame |
| vdisp_end | input | 10 | Count of the first line after active display |
| vblank_start | input | 10 | Count of the first blanked line |
| vblank_end | input | 8 | Low-bit match value that ends blanking |
| vsync_start | input | 10 | Count of the first sync line |
| vsync_end | input | 4 | Low-bit match value that ends sync |
| split_line | input | 10 | Count that fires the split-screen pulse |
| line_cnt | output | 10 | Current scan line count |
| vde | output | 1 | Vertical display enable |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync, active high |
| frame_start | output | 1 | One-cycle pulse when the count wraps to 0 |
| split_hit | output | 1 | One-cycle pulse when the count reaches the split line |

## Verification
A wrong count shows up on `line_cnt` in the cycle after the faulty `line_end`. It also moves the edges of `vde`, `vblank` and `vsync` by whole lines from then on. A window machine stuck in the wrong state shows up as a blanking or sync level that is wrong on the very next line, or as a window that spills over the wrap when it should close, or closes when it should spill over. A fault in the divider makes every later line appear at twice or half the expected rate. A wrong pulse register shows up as a missing, extra or misplaced `frame_start` or `split_hit` within one line.

// File: rtl/vt_pkg.sv
package vt_pkg;
    typedef enum logic {
        WIN_IDLE   = 1'b0,
        WIN_ACTIVE = 1'b1
    } win_state_t;
endpackage

// File: rtl/vt_line_ctr.sv
module vt_line_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line_end,
    input  logic         div2,
    input  logic [W-1:0] total,
    output logic         adv,
    output logic [W-1:0] cnt,
    output logic [W-1:0] nxt,
    output logic         frame_start
);
    logic half_q;
    logic wrap;

    // half-rate phase: only toggles while division is on
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        half_q <= 1'b0;
        else if (!div2)    half_q <= 1'b0;
        else if (line_end) half_q <= ~half_q;
    end

    assign adv  = line_end & (~div2 | half_q);
    assign wrap = (cnt == total);
    assign nxt  = wrap ? '0 : cnt + W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= adv & wrap;
            if (adv) cnt <= nxt;
        end
    end

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == total) |=> (cnt == '0));
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt != total) |=> (cnt == $past(cnt) + W'(1)));
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_end) |=> $stable(cnt));
    a_r7_skip_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (div2 && line_end && !half_q) |=> $stable(cnt));
endmodule

// File: rtl/vt_window_fsm.sv
module vt_window_fsm
    import vt_pkg::*;
#(
    parameter int W  = 10,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [W-1:0]  nxt,
    input  logic [W-1:0]  start,
    input  logic [EW-1:0] stop,
    output logic          active
);
    win_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    // Enter on full-width start match, Leave on low-bit end match
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE:   if (adv && nxt == start)         state_d = WIN_ACTIVE;
            WIN_ACTIVE: if (adv && nxt[EW-1:0] == stop)  state_d = WIN_IDLE;
            default:    state_d = WIN_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == WIN_ACTIVE);
    end

    // R4 / R6 open
    a_r4_win_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !active && nxt == start) |=> active);
    // R5 / R6 close
    a_r5_win_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && active && nxt[EW-1:0] == stop) |=> !active);
    a_r5_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv) |=> $stable(active));
endmodule

// File: rtl/vtiming_gen.sv
module vtiming_gen #(
    parameter int LW  = 10,
    parameter int BEW = 8,
    parameter int SEW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_end,
    input  logic           div2,
    input  logic           sync_en,
    input  logic [LW-1:0]  vtotal,
    input  logic [LW-1:0]  vdisp_end,
    input  logic [LW-1:0]  vblank_start,
    input  logic [BEW-1:0] vblank_end,
    input  logic [LW-1:0]  vsync_start,
    input  logic [SEW-1:0] vsync_end,
    input  logic [LW-1:0]  split_line,
    output logic [LW-1:0]  line_cnt,
    output logic           vde,
    output logic           vblank,
    output logic           vsync,
    output logic           frame_start,
    output logic           split_hit
);
    logic          adv;
    logic [LW-1:0] nxt;
    logic          sync_win;

    vt_line_ctr #(.W(LW)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_end    (line_end),
        .div2        (div2),
        .total       (vtotal),
        .adv         (adv),
        .cnt         (line_cnt),
        .nxt         (nxt),
        .frame_start (frame_start)
    );

    vt_window_fsm #(.W(LW), .EW(BEW)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .nxt    (nxt),
        .start  (vblank_start),
        .stop   (vblank_end),
        .active (vblank)
    );

    vt_window_fsm #(.W(LW), .EW(SEW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .nxt    (nxt),
        .start  (vsync_start),
        .stop   (vsync_end),
        .active (sync_win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) split_hit <= 1'b0;
        else        split_hit <= adv & (nxt == split_line);
    end

    assign vde   = (line_cnt < vdisp_end);
    assign vsync = sync_win & sync_en;

    a_r2_frame_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (line_cnt == '0));
    a_r9_split_at_line: assert property (@(posedge clk) disable iff (!rst_n)
        split_hit |-> (line_cnt == $past(split_line)));
    a_r9_split_single: assert property (@(posedge clk) disable iff (!rst_n)
        split_hit |=> !split_hit);
endmodule

// File: tb/vtiming_gen_test.sv
module vtiming_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_end = 1'b0;
    logic       div2 = 1'b0;
    logic       sync_en = 1'b1;
    logic [9:0] vtotal, vdisp_end, vblank_start, vsync_start, split_line;
    logic [7:0] vblank_end;
    logic [3:0] vsync_end;
    logic [9:0] line_cnt;
    logic       vde, vblank, vsync, frame_start, split_hit;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vtiming_gen uut (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .div2(div2),
        .sync_en(sync_en), .vtotal(vtotal), .vdisp_end(vdisp_end),
        .vblank_start(vblank_start), .vblank_end(vblank_end),
        .vsync_start(vsync_start), .vsync_end(vsync_end),
        .split_line(split_line), .line_cnt(line_cnt), .vde(vde),
        .vblank(vblank), .vsync(vsync), .frame_start(frame_start),
        .split_hit(split_hit)
    );

    // {line_cnt, vde, vblank, vsync, split_hit, frame_start} after each line
    localparam logic [14:0] VEC [12] = '{
        {10'd1, 5'b10000}, {10'd2, 5'b10000}, {10'd3, 5'b10010},
        {10'd4, 5'b10000}, {10'd5, 5'b10000}, {10'd6, 5'b00000},
        {10'd7, 5'b01000}, {10'd8, 5'b01100}, {10'd9, 5'b00000},
        {10'd0, 5'b10001}, {10'd1, 5'b10000}, {10'd2, 5'b10000}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic setup();
        div2 = 1'b0; sync_en = 1'b1;
        vtotal = 10'd9; vdisp_end = 10'd6; vblank_start = 10'd7;
        vblank_end = 8'd9; vsync_start = 10'd8; vsync_end = 4'd9;
        split_line = 10'd3;
    endtask

    task automatic do_reset();
        line_end = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk) line_end = 1'b1;
        @(negedge clk) line_end = 1'b0;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hits;
        int frames;
        setup();
        do_reset();
        // R1 reset state
        chk("R1", "line_cnt", line_cnt, 0);
        chk("R1", "vblank", vblank, 0);
        chk("R1", "vsync", vsync, 0);
        chk("R1", "vde", vde, 1);
        chk("R1", "frame_start", frame_start, 0);
        chk("R1", "split_hit", split_hit, 0);

        // table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 12; i++) begin
            pulse();
            chk("R2", "line_cnt", line_cnt, int'(VEC[i][14:5]));
            chk("R3", "vde", vde, int'(VEC[i][4]));
            chk("R4", "vblank", vblank, int'(VEC[i][3]));
            chk("R6", "vsync", vsync, int'(VEC[i][2]));
            chk("R9", "split_hit", split_hit, int'(VEC[i][1]));
            chk("R2", "frame_start", frame_start, int'(VEC[i][0]));
        end

        // R2: no line_end, no change
        repeat (6) @(negedge clk);
        chk("R2", "idle line_cnt", line_cnt, 2);

        // R8: sync gated off, window still runs
        setup(); sync_en = 1'b0; do_reset();
        repeat (8) pulse();
        chk("R8", "line_cnt", line_cnt, 8);
        chk("R8", "vsync gated", vsync, 0);
        chk("R8", "vblank", vblank, 1);
        sync_en = 1'b1;
        #1;
        chk("R8", "vsync reenabled", vsync, 1);

        // R5 R6: windows carry over the wrap
        setup(); vblank_end = 8'd2; vsync_end = 4'd1; do_reset();
        repeat (10) pulse();
        chk("R5", "line_cnt", line_cnt, 0);
        chk("R5", "vblank line0", vblank, 1);
        chk("R6", "vsync line0", vsync, 1);
        pulse();
        chk("R5", "vblank line1", vblank, 1);
        chk("R6", "vsync line1", vsync, 0);
        pulse();
        chk("R5", "vblank line2", vblank, 0);

        // R7: halved line clock
        setup(); div2 = 1'b1; do_reset();
        pulse();
        chk("R7", "after 1", line_cnt, 0);
        pulse();
        chk("R7", "after 2", line_cnt, 1);
        pulse();
        chk("R7", "after 3", line_cnt, 1);
        pulse();
        chk("R7", "after 4", line_cnt, 2);

        // R9: 3FFh disables the split; R2: frame pulses counted
        setup(); split_line = 10'h3FF; do_reset();
        hits = 0; frames = 0;
        for (int i = 0; i < 20; i++) begin
            pulse();
            if (split_hit) hits++;
            if (frame_start) frames++;
        end
        chk("R9", "split pulses", hits, 0);
        chk("R2", "frame pulses", frames, 2);

        // R4: start beyond total never blanks
        setup(); vblank_start = 10'd500; do_reset();
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            pulse();
            if (vblank) hits++;
        end
        chk("R4", "blank lines", hits, 0);

        // R2: total of zero wraps every line
        setup(); vtotal = 10'd0; do_reset();
        pulse();
        chk("R2", "total0 line_cnt", line_cnt, 0);
        chk("R2", "total0 frame_start", frame_start, 1);
        @(negedge clk);
        chk("R2", "total0 pulse width", frame_start, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule